// File: doc/BRIEF.md
# Banked GPIO and Pin-Function Controller

This block gives software control over a parameterised set of general-purpose pins through a 32-bit register port with separate read and write strobes. The pins are grouped into banks of 32. Each register group holds one word per bank, and the groups are spaced by the bank count. For each pin, software can set or clear the output value, enable the output driver, pick one of four functions and read the synchronised pin level.

Every pin also has an event flag. In both-edge mode the flag is raised by any change of the synchronised level. In level mode it is raised on every cycle the level is high. Flags are cleared by writing ones. A per-pin enable masks each flag, and the enabled flags are combined into a single interrupt line. The alternate peripherals behind function codes 1 to 3 live outside the block. The block only presents the 2-bit code per pin.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset, pinOut, pinOe, pinFunc, irqOut and rdData are all zero, and every register reads as zero while the pins stay low.
- R2: A write to a set-output word (group 0) sets the output bits where the data is 1. A write to a clear-output word (group 1) clears the output bits where the data is 1. Zero bits leave the outputs unchanged. Both words read as zero.
- R3: The output-value word (group 2) can be written directly and read back, and pinOut follows it.
- R4: The output-enable word (group 4) can be written and read back, and pinOe[i] follows bit i of it (1 drives the pin).
- R5: pinFunc[2i+1:2i] is {bit i of the function-high word (group 9), bit i of the function-low word (group 8)}. Code 0 is plain GPIO.
- R6: The word for group g and bank b is at byte address 4·(g·BANKS + b), with BANKS = 1 + (NUM_PINS−1)/32. With 40 pins, bank 1 of the output-enable group is at 0x24.
- R7: The input word (group 3) returns the pin levels after a two-flop synchroniser. A level applied before clock edge A is first returned by a read strobed at edge A+2.
- R8: In both-edge mode (bit i of the mode word, group 11, is 0), a rise or fall of pin i sets bit i of the flag word (group 5) on the third clock edge after the change. Writing 1 to a flag bit clears it, and writing 0 leaves it.
- R9: In level mode (mode bit 1), the flag is set on every cycle the synchronised level is high, so a clear does not stick while the pin is high. A falling pin sets no flag.
- R10: When a flag set and a write-1-to-clear of the same bit fall in the same cycle, the flag ends up set.
- R11: The identity word (group 7) is the flag word ANDed with the enable word (group 6). irqOut is the OR of all identity bits. A masked flag still reads in the flag word.
- R12: Read data appears one cycle after the read strobe. Unmapped or misaligned addresses read zero. Writes to the input and identity words are ignored.
- R13: The serial-data map word (group 10) stores and returns all 32 bits per bank.
- R14: Bits for pins at or beyond NUM_PINS read as zero in every per-pin word and never raise an interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, applied at the clock edge |
| rdEn | input | 1 | Read strobe; data is returned on the next cycle |
| addr | input | ADDR_W | Byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data |
| pinIn | input | NUM_PINS | Asynchronous pin levels |
| pinOut | output | NUM_PINS | Output value per pin |
| pinOe | output | NUM_PINS | Output enable per pin |
| pinFunc | output | 2·NUM_PINS | 2-bit function code per pin |
| irqOut | output | 1 | Combined interrupt |

## Verification
Output control is tried with set, clear and direct writes carrying mixed one and zero patterns. A zero-data set write then shows that zero bits do not disturb outputs. Writes to bank 1 separate the stride-based layout from a flat one, and they expose the always-zero bits above pin 39. Single pin transitions are read back in consecutive cycles, which pins down the synchroniser depth. The same transition is then used in edge mode and in level mode: a rising pin tells the two modes apart by whether a clear sticks, and a falling pin tells them apart by whether it raises a flag. A clear timed onto the very cycle a flag is raised shows which of the two wins.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  localparam int GRP_COUNT = 12;

  typedef enum logic [3:0] {
    GRP_SET   = 4'd0,
    GRP_CLR   = 4'd1,
    GRP_OUT   = 4'd2,
    GRP_IN    = 4'd3,
    GRP_OE    = 4'd4,
    GRP_FLAG  = 4'd5,
    GRP_ENA   = 4'd6,
    GRP_IDENT = 4'd7,
    GRP_FLO   = 4'd8,
    GRP_FHI   = 4'd9,
    GRP_SDMAP = 4'd10,
    GRP_MODE  = 4'd11
  } regGroup_e;

  // strobes handed from the address decoder to the datapath
  typedef struct packed {
    logic      wrHit;
    logic      rdHit;
    regGroup_e grp;
    logic [7:0] bank;
  } regStrobe_t;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_mux_pkg::*;
#(
  parameter int BANKS  = 2,
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb
);

  logic [ADDR_W-3:0] wordIdx;
  logic              aligned;

  assign wordIdx = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  // group g, bank b lives at word g*BANKS + b
  always_comb begin
    strb = '0;
    for (int g = 0; g < GRP_COUNT; g++) begin
      for (int b = 0; b < BANKS; b++) begin
        if (aligned && (int'(wordIdx) == g * BANKS + b)) begin
          strb.wrHit = wrEn;
          strb.rdHit = rdEn;
          strb.grp   = regGroup_e'(4'(g));
          strb.bank  = 8'(b);
        end
      end
    end
  end

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int W           = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinIn,
  input  logic [W-1:0] levelMode,
  output logic [W-1:0] level,
  output logic [W-1:0] pinEvent
);

  logic [W-1:0] stageQ [SYNC_STAGES];
  logic [W-1:0] prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) stageQ[s] <= '0;
      prevQ <= '0;
    end else begin
      stageQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) stageQ[s] <= stageQ[s-1];
      prevQ <= stageQ[SYNC_STAGES-1];
    end
  end

  assign level = stageQ[SYNC_STAGES-1];

  for (genvar i = 0; i < W; i++) begin : g_evt
    assign pinEvent[i] = levelMode[i] ? level[i] : (level[i] ^ prevQ[i]);
  end

endmodule

// File: rtl/gpio_pin_datapath.sv
module gpio_pin_datapath
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int BANKS    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strb,
  input  logic [31:0]           wrData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [31:0]           rdData,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [2*NUM_PINS-1:0] pinFunc,
  output logic                  irqOut
);

  localparam int PADDED = BANKS * 32;
  localparam logic [PADDED-1:0] VALID = {PADDED{1'b1}} >> (PADDED - NUM_PINS);

  logic [PADDED-1:0] outQ, oeQ, flagQ, enaQ, fLoQ, fHiQ, modeQ;
  logic [31:0]       sdMapQ [BANKS];
  logic [PADDED-1:0] pinPad, levelNow, eventNow, flagClr, ident;
  logic [31:0]       rdWord;

  assign pinPad = PADDED'(pinIn);

  gpio_edge_detect #(.W(PADDED), .SYNC_STAGES(2)) u_edge (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinPad),
    .levelMode(modeQ),
    .level    (levelNow),
    .pinEvent (eventNow)
  );

  always_comb begin
    flagClr = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (strb.wrHit && strb.grp == GRP_FLAG && strb.bank == 8'(b))
        flagClr[b*32 +: 32] = wrData;
    end
  end

  assign ident  = flagQ & enaQ;
  assign irqOut = |ident;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ  <= '0;
      oeQ   <= '0;
      flagQ <= '0;
      enaQ  <= '0;
      fLoQ  <= '0;
      fHiQ  <= '0;
      modeQ <= '0;
      for (int b = 0; b < BANKS; b++) sdMapQ[b] <= '0;
    end else begin
      // a new event outranks a clear in the same cycle
      flagQ <= ((flagQ & ~flagClr) | eventNow) & VALID;
      for (int b = 0; b < BANKS; b++) begin
        if (strb.wrHit && strb.bank == 8'(b)) begin
          case (strb.grp)
            GRP_SET:   outQ[b*32 +: 32]  <= outQ[b*32 +: 32] | (wrData & VALID[b*32 +: 32]);
            GRP_CLR:   outQ[b*32 +: 32]  <= outQ[b*32 +: 32] & ~wrData;
            GRP_OUT:   outQ[b*32 +: 32]  <= wrData & VALID[b*32 +: 32];
            GRP_OE:    oeQ[b*32 +: 32]   <= wrData & VALID[b*32 +: 32];
            GRP_ENA:   enaQ[b*32 +: 32]  <= wrData & VALID[b*32 +: 32];
            GRP_FLO:   fLoQ[b*32 +: 32]  <= wrData & VALID[b*32 +: 32];
            GRP_FHI:   fHiQ[b*32 +: 32]  <= wrData & VALID[b*32 +: 32];
            GRP_MODE:  modeQ[b*32 +: 32] <= wrData & VALID[b*32 +: 32];
            GRP_SDMAP: sdMapQ[b]         <= wrData;
            default:   ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdWord = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (strb.bank == 8'(b)) begin
        case (strb.grp)
          GRP_OUT:   rdWord = outQ[b*32 +: 32];
          GRP_IN:    rdWord = levelNow[b*32 +: 32] & VALID[b*32 +: 32];
          GRP_OE:    rdWord = oeQ[b*32 +: 32];
          GRP_FLAG:  rdWord = flagQ[b*32 +: 32];
          GRP_ENA:   rdWord = enaQ[b*32 +: 32];
          GRP_IDENT: rdWord = ident[b*32 +: 32];
          GRP_FLO:   rdWord = fLoQ[b*32 +: 32];
          GRP_FHI:   rdWord = fHiQ[b*32 +: 32];
          GRP_SDMAP: rdWord = sdMapQ[b];
          GRP_MODE:  rdWord = modeQ[b*32 +: 32];
          default:   rdWord = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strb.rdHit ? rdWord : '0;
  end

  assign pinOut = outQ[NUM_PINS-1:0];
  assign pinOe  = oeQ[NUM_PINS-1:0];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_func
    assign pinFunc[2*i +: 2] = {fHiQ[i], fLoQ[i]};
  end

endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [2*NUM_PINS-1:0] pinFunc,
  output logic                  irqOut
);

  localparam int BANKS = 1 + (NUM_PINS - 1) / 32;

  regStrobe_t strb;

  gpio_reg_decode #(.BANKS(BANKS), .ADDR_W(ADDR_W)) u_decode (
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .strb(strb)
  );

  gpio_pin_datapath #(.NUM_PINS(NUM_PINS), .BANKS(BANKS)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .pinIn  (pinIn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .pinFunc(pinFunc),
    .irqOut (irqOut)
  );

endmodule

// File: rtl/gpio_mux_checker.sv
module gpio_mux_checker #(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [ADDR_W-1:0]     addr,
  input logic [31:0]           wrData,
  input logic [31:0]           rdData,
  input logic [NUM_PINS-1:0]   pinIn,
  input logic [NUM_PINS-1:0]   pinOut,
  input logic [NUM_PINS-1:0]   pinOe,
  input logic [2*NUM_PINS-1:0] pinFunc,
  input logic                  irqOut
);

  localparam int BANKS   = 1 + (NUM_PINS - 1) / 32;
  localparam int W0      = (NUM_PINS < 32) ? NUM_PINS : 32;
  localparam int ADR_SET = 0;
  localparam int ADR_CLR = 4 * BANKS;
  localparam int ADR_IN  = 12 * BANKS;
  localparam int ADR_OE  = 16 * BANKS;
  localparam int ADR_END = 48 * BANKS;

  logic [2:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOut == '0 && pinOe == '0 && pinFunc == '0 && !irqOut && rdData == '0));

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) == ADR_SET) |=>
      ((pinOut[W0-1:0] & $past(wrData[W0-1:0])) == $past(wrData[W0-1:0])));

  assert_clear_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) == ADR_CLR) |=> ((pinOut[W0-1:0] & $past(wrData[W0-1:0])) == '0));

  assert_oe_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) == ADR_OE) |=> (pinOe[W0-1:0] == $past(wrData[W0-1:0])));

  assert_sync_depth_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4 && rdEn && int'(addr) == ADR_IN) |=> (rdData[0] == $past(pinIn[0], 3)));

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) >= ADR_END) |=> (rdData == '0));

endmodule

bind gpio_mux_ctrl gpio_mux_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .pinIn  (pinIn),
  .pinOut (pinOut),
  .pinOe  (pinOe),
  .pinFunc(pinFunc),
  .irqOut (irqOut)
);

// File: tb/test_gpio_mux_ctrl.sv
module test_gpio_mux_ctrl;

  localparam int NP = 40;
  // byte addresses for 40 pins (two banks): group g bank b at 8g+4b
  localparam logic [7:0] A_SET0 = 8'h00, A_SET1 = 8'h04, A_CLR0 = 8'h08;
  localparam logic [7:0] A_OUT0 = 8'h10, A_OUT1 = 8'h14, A_IN0 = 8'h18;
  localparam logic [7:0] A_OE1 = 8'h24, A_FLAG0 = 8'h28, A_ENA0 = 8'h30;
  localparam logic [7:0] A_ID0 = 8'h38, A_ID1 = 8'h3C, A_FLO0 = 8'h40;
  localparam logic [7:0] A_FHI0 = 8'h48, A_SD0 = 8'h50, A_SD1 = 8'h54;
  localparam logic [7:0] A_MODE0 = 8'h58;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut, pinOe;
  logic [2*NP-1:0] pinFunc;
  logic          irqOut;
  int            checkCnt = 0;
  int            failCnt = 0;

  always #10 clk = ~clk;

  gpio_mux_ctrl #(.NUM_PINS(NP), .ADDR_W(8)) i_gpio_mux_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .pinFunc(pinFunc), .irqOut(irqOut)
  );

  task automatic check(input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1", "pinOut", 80'(pinOut), 80'h0);
    check("R1", "pinOe", 80'(pinOe), 80'h0);
    check("R1", "pinFunc", 80'(pinFunc), 80'h0);
    check("R1", "irqOut", 80'(irqOut), 80'h0);
    doRead(A_FLAG0, d);
    check("R1", "flag read", 80'(d), 80'h0);
  endtask

  task automatic testSetClear();
    logic [31:0] d;
    doWrite(A_SET0, 32'h0F0F_00FF);
    check("R2", "after set", 80'(pinOut[31:0]), 80'h0F0F_00FF);
    doWrite(A_CLR0, 32'h0000_00F0);
    check("R2", "after clear", 80'(pinOut[31:0]), 80'h0F0F_000F);
    doWrite(A_SET0, 32'h0);
    doWrite(A_CLR0, 32'h0);
    check("R2", "zero data", 80'(pinOut[31:0]), 80'h0F0F_000F);
    doRead(A_OUT0, d);
    check("R2", "out read", 80'(d), 80'h0F0F_000F);
    doRead(A_SET0, d);
    check("R2", "set word reads zero", 80'(d), 80'h0);
    doWrite(A_OUT0, 32'h1234_5678);
    doRead(A_OUT0, d);
    check("R3", "direct out read", 80'(d), 80'h1234_5678);
    check("R3", "direct out pins", 80'(pinOut[31:0]), 80'h1234_5678);
  endtask

  task automatic testBankLayout();
    logic [31:0] d;
    doWrite(A_SET1, 32'hFFFF_FFFF);
    doRead(A_OUT1, d);
    check("R14", "bank1 out upper bits", 80'(d), 80'hFF);
    check("R6", "bank1 pins", 80'(pinOut[39:32]), 80'hFF);
    doWrite(A_OE1, 32'h0000_00A5);
    check("R4", "bank1 oe pins", 80'(pinOe[39:32]), 80'hA5);
    check("R6", "bank0 oe untouched", 80'(pinOe[31:0]), 80'h0);
    doRead(A_OE1, d);
    check("R4", "bank1 oe read", 80'(d), 80'hA5);
  endtask

  task automatic testFunction();
    doWrite(A_FLO0, 32'h0000_0008);
    doWrite(A_FHI0, 32'h0000_0028);
    check("R5", "pin3 code", 80'(pinFunc[7:6]), 80'h3);
    check("R5", "pin4 code", 80'(pinFunc[9:8]), 80'h0);
    check("R5", "pin5 code", 80'(pinFunc[11:10]), 80'h2);
  endtask

  task automatic testInputEdge();
    logic [31:0] d;
    pinIn[5] = 1'b1;
    doRead(A_IN0, d);
    check("R7", "level at edge A", 80'(d[5]), 80'h0);
    doRead(A_IN0, d);
    check("R7", "level at edge B", 80'(d[5]), 80'h0);
    doRead(A_IN0, d);
    check("R7", "level at edge C", 80'(d[5]), 80'h1);
    doWrite(A_ENA0, 32'h0000_0020);
    check("R8", "irq from rising edge", 80'(irqOut), 80'h1);
    doRead(A_ID0, d);
    check("R11", "identity", 80'(d), 80'h20);
    doWrite(A_FLAG0, 32'h0000_0020);
    check("R8", "irq after clear", 80'(irqOut), 80'h0);
    pinIn[5] = 1'b0;
    idle(2);
    check("R8", "no flag before third edge", 80'(irqOut), 80'h0);
    idle(1);
    check("R8", "flag from falling edge", 80'(irqOut), 80'h1);
    doWrite(A_ENA0, 32'h0);
    check("R11", "masked irq", 80'(irqOut), 80'h0);
    doRead(A_FLAG0, d);
    check("R11", "masked flag still readable", 80'(d), 80'h20);
    doRead(A_ID1, d);
    check("R14", "bank1 identity", 80'(d), 80'h0);
    doWrite(A_FLAG0, 32'h0000_0020);
    doRead(A_FLAG0, d);
    check("R8", "flag cleared", 80'(d), 80'h0);
  endtask

  task automatic testLevelMode();
    logic [31:0] d;
    doWrite(A_MODE0, 32'h0000_0040);
    pinIn[6] = 1'b1;
    idle(4);
    doWrite(A_FLAG0, 32'h0000_0040);
    doRead(A_FLAG0, d);
    check("R9", "clear does not stick while high", 80'(d[6]), 80'h1);
    pinIn[6] = 1'b0;
    idle(4);
    doWrite(A_FLAG0, 32'h0000_0040);
    idle(3);
    doRead(A_FLAG0, d);
    check("R9", "no flag on fall in level mode", 80'(d[6]), 80'h0);
  endtask

  task automatic testSetWins();
    logic [31:0] d;
    pinIn[7] = 1'b1;
    idle(2);
    doWrite(A_FLAG0, 32'h0000_0080);
    doRead(A_FLAG0, d);
    check("R10", "set beats clear", 80'(d[7]), 80'h1);
    doWrite(A_FLAG0, 32'h0000_0080);
    doRead(A_FLAG0, d);
    check("R8", "later clear works", 80'(d[7]), 80'h0);
  endtask

  task automatic testReadOnly();
    logic [31:0] d;
    doRead(8'h60, d);
    check("R12", "unmapped read", 80'(d), 80'h0);
    doRead(8'h12, d);
    check("R12", "misaligned read", 80'(d), 80'h0);
    doWrite(A_IN0, 32'hFFFF_FFFF);
    doRead(A_IN0, d);
    check("R12", "input write ignored", 80'(d), 80'(pinIn[31:0]));
    doWrite(A_ID0, 32'hFFFF_FFFF);
    doRead(A_ID0, d);
    check("R12", "identity write ignored", 80'(d), 80'h0);
    check("R12", "no irq after identity write", 80'(irqOut), 80'h0);
  endtask

  task automatic testSerialMap();
    logic [31:0] d;
    doWrite(A_SD0, 32'hA5C3_0F96);
    doWrite(A_SD1, 32'hDEAD_BEEF);
    doRead(A_SD0, d);
    check("R13", "map bank0", 80'(d), 80'hA5C3_0F96);
    doRead(A_SD1, d);
    check("R13", "map bank1", 80'(d), 80'hDEAD_BEEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSetClear();
    testBankLayout();
    testFunction();
    testInputEdge();
    testLevelMode();
    testSetWins();
    testReadOnly();
    testSerialMap();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule